// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block divides the system clock into time quanta and arranges a run of quanta into one nominal bit of a CAN-style serial node. Each bit holds a one-quantum sync segment, then a propagation segment, a first phase segment and a second phase segment, each with its own programmed length. The receive line is sampled once per bit at the end of the first phase segment. Surrounding logic uses the strobes to shift received bits in and to launch transmitted bits.

When triple sampling is enabled, the received value is the majority of three samples. The last sample is taken at the sample point and the other two are taken half a quantum and one quantum before it. The length of the second phase segment can come from its own field. It can also be derived automatically from the first phase segment. In both cases it never drops below the two-quantum processing time. All settings are captured at the first clock of a bit, so a bit is never built from a mix of old and new values.

Top module: `can_bit_timer`

## Requirements
- R1: A time quantum lasts 2*(presc+1) clocks. `tq_tick` is high for exactly the last clock of every quantum and low on all other clocks.
- R2: A bit lasts 1+P+A+B quanta, where P=prop_len+1, A=ph1_len+1 and B is the phase-2 length from R4/R5. `bit_start` is high in the first clock of each bit and `tx_update` is high in its last clock, once per bit.
- R3: `sample_stb` is high for exactly one clock per bit: the last clock of quantum number P+A, counting the sync quantum as number 0.
- R4: With `ph2_auto`=0 the phase-2 length is ph2_len+1 quanta, raised to 2 when that value is 1.
- R5: With `ph2_auto`=1 the phase-2 length is the greater of A and 2, and `ph2_len` is ignored.
- R6: With `tri_en`=0, `rx_bit` takes the value of `rx_in` at the clock edge that ends the sample clock, and holds it until the next sample. Values of `rx_in` at other edges have no effect.
- R7: With `tri_en`=1, `rx_bit` becomes the majority of `rx_in` at three edges: the end of the quantum before the sample quantum, the edge presc+1 clocks before the sample edge, and the sample edge itself. A single deviating sample does not change the result.
- R8: All configuration inputs are captured only at the edge that ends the `bit_start` clock. Changes made later in a bit do not affect that bit's timing or sampling.
- R9: After reset, `bit_start` is high, `tq_tick`, `sample_stb` and `tx_update` are low, and `rx_bit` is 1 (the recessive level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc | input | 6 | Quantum prescaler; a quantum lasts 2*(presc+1) clocks |
| prop_len | input | 3 | Propagation segment length minus one, in quanta |
| ph1_len | input | 3 | Phase segment 1 length minus one, in quanta |
| ph2_len | input | 3 | Phase segment 2 length minus one, in quanta (manual mode) |
| ph2_auto | input | 1 | 1: derive phase 2 from phase 1 and the processing time |
| tri_en | input | 1 | 1: three-sample majority vote |
| rx_in | input | 1 | Receive line, synchronous to clk |
| tq_tick | output | 1 | One-clock strobe at the end of each quantum |
| bit_start | output | 1 | High in the first clock of each bit |
| sample_stb | output | 1 | High in the sample clock of each bit |
| rx_bit | output | 1 | Received bit value, updated after each sample |
| tx_update | output | 1 | High in the last clock of each bit |

## Verification
On every cycle, the assertions check that the quantum strobe is a single-clock pulse and that every end of bit is followed at once by a start of bit. They also check that exactly one sample falls in each bit and never in its final quantum, and that the received value only changes right after a sample. The bench alone can show the exact clock positions of every strobe for a given prescaler and set of segment lengths, the clamping and automatic derivation of phase 2, and the majority results when glitches are placed on chosen sample edges. It also shows that settings changed mid-bit leave the current bit untouched.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] presc,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic             ph2_auto,
  input  logic             tri_en,
  input  logic             rx_in,
  output logic             tq_tick,
  output logic             bit_start,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             tx_update
);

  localparam int PC_W = BRP_W + 1;
  localparam int SQ_W = SEG_W + 1;
  localparam int Q_W  = SQ_W + 2;

  logic [BRP_W-1:0] brp_l;
  logic [SQ_W-1:0]  prop_q, ph1_q, ph2_q;
  logic             tri_l;
  logic [PC_W-1:0]  pcnt;
  logic [Q_W-1:0]   qcnt;
  logic             s_early, s_mid, rx_q;

  logic [PC_W-1:0]  pc_last, pc_half;
  logic [Q_W-1:0]   sp_idx, bit_last;
  logic [SQ_W-1:0]  ph1_in, ph2_in, ph2_base, ph2_new;
  logic             maj;

  assign pc_last  = {brp_l, 1'b1};
  assign pc_half  = {1'b0, brp_l};
  assign sp_idx   = Q_W'(prop_q) + Q_W'(ph1_q);
  assign bit_last = sp_idx + Q_W'(ph2_q);

  assign tq_tick    = (pcnt == pc_last);
  assign bit_start  = (pcnt == '0) && (qcnt == '0);
  assign sample_stb = tq_tick && (qcnt == sp_idx);
  assign tx_update  = tq_tick && (qcnt == bit_last);
  assign rx_bit     = rx_q;

  assign ph1_in   = SQ_W'(ph1_len) + SQ_W'(1);
  assign ph2_in   = SQ_W'(ph2_len) + SQ_W'(1);
  assign ph2_base = ph2_auto ? ph1_in : ph2_in;
  assign ph2_new  = (ph2_base < SQ_W'(2)) ? SQ_W'(2) : ph2_base;

  assign maj = (s_early & s_mid) | (s_early & rx_in) | (s_mid & rx_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brp_l   <= '0;
      prop_q  <= SQ_W'(1);
      ph1_q   <= SQ_W'(1);
      ph2_q   <= SQ_W'(2);
      tri_l   <= 1'b0;
      pcnt    <= '0;
      qcnt    <= '0;
      s_early <= 1'b1;
      s_mid   <= 1'b1;
      rx_q    <= 1'b1;
    end else begin
      if (bit_start) begin
        brp_l  <= presc;
        prop_q <= SQ_W'(prop_len) + SQ_W'(1);
        ph1_q  <= ph1_in;
        ph2_q  <= ph2_new;
        tri_l  <= tri_en;
      end
      pcnt <= tq_tick ? '0 : pcnt + PC_W'(1);
      if (tq_tick)
        qcnt <= tx_update ? '0 : qcnt + Q_W'(1);
      if (tq_tick && (qcnt == sp_idx - Q_W'(1)))
        s_early <= rx_in;
      if ((qcnt == sp_idx) && (pcnt == pc_half))
        s_mid <= rx_in;
      if (sample_stb)
        rx_q <= tri_l ? maj : rx_in;
    end
  end

  logic [1:0] samp_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          samp_cnt <= '0;
    else if (tx_update)  samp_cnt <= '0;
    else if (sample_stb) samp_cnt <= samp_cnt + 2'd1;
  end

  p_tick_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

  p_start_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_update |=> bit_start);

  p_one_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_update |-> (samp_cnt == 2'd1));

  p_ph2_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !tx_update);

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(rx_bit));

endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] presc = '0;
  logic [2:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
  logic ph2_auto = 1'b0, tri_en = 1'b0, rx_in = 1'b1;
  logic tq_tick, bit_start, sample_stb, rx_bit, tx_update;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .presc(presc), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .ph2_auto(ph2_auto),
    .tri_en(tri_en), .rx_in(rx_in), .tq_tick(tq_tick),
    .bit_start(bit_start), .sample_stb(sample_stb), .rx_bit(rx_bit),
    .tx_update(tx_update)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ph2(input int ph1, input int ph2, input bit aut);
    int b;
    b = aut ? ph1 + 1 : ph2 + 1;
    return (b < 2) ? 2 : b;
  endfunction

  function automatic bit exp_rx(input bit v, input bit g1, input bit g2, input bit g3, input bit tri_on);
    if (tri_on) return v ^ ((int'(g1) + int'(g2) + int'(g3)) >= 2);
    return v ^ g3;
  endfunction

  task automatic run_bit(input int brp, input int prop, input int ph1, input int ph2,
                         input bit aut, input bit tri_on, input bit v, input int gmode);
    int L, P, A, B, T, sp, cs, c1, c2;
    int tick_err, samp_err, upd_err, start_err;
    bit g1, g2, g3, rexp;
    L = 2 * (brp + 1);
    P = prop + 1; A = ph1 + 1; B = exp_ph2(ph1, ph2, aut);
    T = 1 + P + A + B;
    sp = P + A;
    cs = (sp + 1) * L - 1;
    c1 = sp * L - 1;
    c2 = cs - (brp + 1);
    g1 = (gmode == 1) || (gmode == 4);
    g2 = (gmode == 2) || (gmode == 4) || (gmode == 5);
    g3 = (gmode == 3) || (gmode == 5);
    rexp = exp_rx(v, g1, g2, g3, tri_on);
    tick_err = 0; samp_err = 0; upd_err = 0; start_err = 0;
    check(bit_start == 1'b1, "R2 bit_start at entry", int'(bit_start), 1);
    presc = 6'(brp); prop_len = 3'(prop); ph1_len = 3'(ph1); ph2_len = 3'(ph2);
    ph2_auto = aut; tri_en = tri_on;
    rx_in = v;
    for (int c = 1; c <= T * L; c++) begin
      @(negedge clk);
      if (c < T * L) begin
        if (tq_tick !== ((c % L) == L - 1)) tick_err++;
        if (sample_stb !== (c == cs)) samp_err++;
        if (tx_update !== (c == T * L - 1)) upd_err++;
        if (bit_start !== 1'b0) start_err++;
      end
      if (c == 1) begin
        presc = 6'($urandom_range(0, 63)); prop_len = 3'($urandom_range(0, 7));
        ph1_len = 3'($urandom_range(0, 7)); ph2_len = 3'($urandom_range(0, 7));
        ph2_auto = 1'($urandom_range(0, 1)); tri_en = 1'($urandom_range(0, 1));
      end
      if (c == T * L - 1)
        check(rx_bit == rexp, tri_on ? "R7 majority value" : "R6 single sample value",
              int'(rx_bit), int'(rexp));
      rx_in = v ^ ((c == c1 && g1) || (c == c2 && g2) || (c == cs && g3));
    end
    check(tick_err == 0, "R1/R8 quantum strobe positions", tick_err, 0);
    check(samp_err == 0, "R3/R8 sample strobe position", samp_err, 0);
    check(upd_err == 0 && start_err == 0, "R2/R4/R5 bit length", upd_err + start_err, 0);
    check(bit_start == 1'b1, "R2 next bit_start", int'(bit_start), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    check(bit_start == 1'b1, "R9 reset bit_start", int'(bit_start), 1);
    check(tq_tick == 1'b0 && sample_stb == 1'b0 && tx_update == 1'b0,
          "R9 reset strobes low", int'({tq_tick, sample_stb, tx_update}), 0);
    check(rx_bit == 1'b1, "R9 reset rx_bit", int'(rx_bit), 1);

    run_bit(0, 0, 0, 0, 1'b0, 1'b0, 1'b1, 0);   // R4 clamp: 5 quanta
    run_bit(1, 2, 3, 1, 1'b0, 1'b1, 1'b0, 4);   // R7 two glitches flip
    run_bit(3, 1, 0, 6, 1'b1, 1'b1, 1'b1, 1);   // R5 auto min 2, R7 one glitch
    run_bit(2, 0, 7, 0, 1'b1, 1'b0, 1'b0, 1);   // R5 auto 8, R6 ignores early
    run_bit(63, 7, 7, 7, 1'b0, 1'b1, 1'b1, 5);  // 25 quanta, max prescale
    run_bit(0, 3, 2, 4, 1'b0, 1'b0, 1'b1, 3);   // R6 glitch at sample
    run_bit(1, 1, 1, 1, 1'b0, 1'b0, 1'b0, 2);   // R6 ignores mid sample
    for (int i = 0; i < 40; i++)
      run_bit($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 5));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule